// File: doc/BRIEF.md
# Trimmable One-Second Prescaler

This block divides a fast crystal-derived clock down to a one-cycle pulse once per second. The length of each second is set by a 19-bit trim word. The upper 17 bits give the whole number of input clocks per second, less one. The lower 2 bits are a fraction in quarters of a clock. The fraction is realised by adding a single extra clock to some seconds of a repeating four-second frame. Over any aligned four seconds, the average period then has a resolution of one quarter clock.

Software writes the whole trim word in one access, normally just after a tick. The word is held in a staging register and does not touch the running divider. It is copied into the active setting on the same clock edge that issues the next tick, so the second already in progress always finishes with the setting it started with.

Top module: `rtc_rate_trim`

## Requirements
- R1: While reset is low at a clock edge, the divider count, the frame index and the tick are cleared and the active trim returns to the reset coarse value with fraction 0; the first second after reset therefore lasts reset coarse value + 1 clocks.
- R2: The write word carries the coarse value in bits 18 down to 2 and the fraction in bits 1 down to 0, and both are taken in a single write.
- R3: A second lasts coarse + 1 input clocks, plus one clock when the fraction selects that second.
- R4: A 2-bit frame index advances by one on every tick and wraps from 3 to 0.
- R5: A fraction n adds the extra clock to the seconds whose frame index is below n, so any four consecutive seconds last 4 x (coarse + 1) + n clocks in total.
- R6: A write does not change the active setting; the second during which it is made keeps the old period.
- R7: A pending staged word is copied to the active setting on the edge that raises the tick; a write sampled on that same edge is kept for the following boundary.
- R8: When several writes arrive before a boundary, the last one is the one applied.
- R9: The tick is high for exactly one clock when coarse is at least 1.
- R10: The divider count never passes the end value of the current second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-derived input clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | One-cycle write strobe for the trim word |
| wr_data_i | input | 19 | Trim word: coarse in [18:2], fraction in [1:0] |
| tick_o | output | 1 | One-cycle pulse at each second boundary |

## Verification
On every cycle, the assertions check that the count stays within the current end value, that the count is zero whenever the tick is high, that the tick lasts a single cycle, that the frame index moves only at a tick, and that the active setting holds between boundaries. Only the bench's scenarios can show the actual period lengths and where the quarter-clock extras fall in the frame. The same holds for the one-second delay before a write takes effect, for the handling of a write that lands on the boundary edge, and for last-write-wins staging.

// File: rtl/rtc_adj_pkg.sv
// Package: shared widths and the trim word layout for the one-second prescaler.
// Assumes the fraction field sits in the low bits of the word written by software.
package rtc_adj_pkg;
    localparam int COARSE_W = 17;
    localparam int FRAC_W   = 2;
    localparam int FRAME_N  = 1 << FRAC_W;
    localparam int CNT_W    = COARSE_W + 1;

    typedef logic [COARSE_W-1:0] coarse_t;
    typedef logic [FRAC_W-1:0]   frac_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef struct packed {
        coarse_t coarse;
        frac_t   frac;
    } trim_t;

    localparam int TRIM_W = $bits(trim_t);
endpackage

// File: rtl/rtc_adj_stage.sv
// Trim staging: holds the software word until the next boundary, then copies it
// into the active setting on the edge that issues the tick.
// Assumes load_i is high for exactly the cycle in which the current second ends.
module rtc_adj_stage
    import rtc_adj_pkg::*;
#(
    parameter trim_t RST_TRIM = '0
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  wr_en_i,
    input  trim_t wr_trim_i,
    input  logic  load_i,
    output trim_t act_o
);
    trim_t staged_q;
    trim_t act_q;
    logic  pend_q;

    // Capture writes into staging, and move a pending word to active at the boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            staged_q <= RST_TRIM;
            act_q    <= RST_TRIM;
            pend_q   <= 1'b0;
        end else begin
            if (wr_en_i) begin
                staged_q <= wr_trim_i;
            end
            if (load_i && pend_q) begin
                act_q <= staged_q;
            end
            pend_q <= wr_en_i | (pend_q & ~load_i);
        end
    end

    assign act_o = act_q;

    p_hold_between_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(act_q));

    p_pending_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !wr_en_i) |=> !pend_q);
endmodule

// File: rtl/rtc_adj_frame.sv
// Frame sequencer: steps a frame index once per second and flags the seconds
// that receive the extra clock (index below the fraction value).
// Assumes adv_i pulses once per second boundary.
module rtc_adj_frame
    import rtc_adj_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  adv_i,
    input  frac_t frac_i,
    output logic  extra_o
);
    frac_t idx_q;

    // Advance the frame index at each boundary; it wraps naturally at FRAME_N.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= idx_q + frac_t'(1);
        end
    end

    // Select this second for the extra clock when its index is below the fraction.
    always_comb begin
        extra_o = (idx_q < frac_i);
    end

    p_frame_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> (idx_q == frac_t'($past(idx_q) + frac_t'(1))));

    p_frame_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(idx_q));
endmodule

// File: rtl/rtc_adj_divider.sv
// Period divider: counts input clocks from zero to coarse (+1 when extra) and
// raises a registered one-cycle tick when the end value is reached.
// Assumes coarse and extra change only on the edge that ends a second.
module rtc_adj_divider
    import rtc_adj_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  coarse_t coarse_i,
    input  logic    extra_i,
    output logic    end_o,
    output logic    tick_o
);
    cnt_t cnt_q;
    cnt_t limit;
    logic tick_q;

    // Form the end value of the current second.
    always_comb begin
        limit = {1'b0, coarse_i} + {{COARSE_W{1'b0}}, extra_i};
        end_o = (cnt_q == limit);
    end

    // Count clocks within the second and register the boundary pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= end_o ? '0 : cnt_q + cnt_t'(1);
            tick_q <= end_o;
        end
    end

    assign tick_o = tick_q;

    p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= limit);

    p_tick_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q |-> (cnt_q == '0));

    p_tick_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_q && coarse_i != '0) |=> !tick_q);
endmodule

// File: rtl/rtc_rate_trim.sv
// Top: one-second prescaler with a staged coarse/fraction trim word.
// Assumes writes arrive as one-cycle strobes; the clock is the crystal-derived clock.
module rtc_rate_trim
    import rtc_adj_pkg::*;
#(
    parameter int unsigned RST_COARSE = 32767
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [TRIM_W-1:0] wr_data_i,
    output logic              tick_o
);
    localparam trim_t RST_TRIM = '{coarse: coarse_t'(RST_COARSE), frac: '0};

    trim_t act;
    logic  sec_end;
    logic  extra;

    rtc_adj_stage #(.RST_TRIM(RST_TRIM)) stage_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_trim_i (trim_t'(wr_data_i)),
        .load_i    (sec_end),
        .act_o     (act)
    );

    rtc_adj_frame frame_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (sec_end),
        .frac_i  (act.frac),
        .extra_o (extra)
    );

    rtc_adj_divider div_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .coarse_i (act.coarse),
        .extra_i  (extra),
        .end_o    (sec_end),
        .tick_o   (tick_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> !tick_o);
endmodule

// File: tb/rtc_rate_trim_tb_top.sv
module rtc_rate_trim_tb_top;
    localparam int RSTC   = 99;
    localparam int MAXP   = 2000;
    localparam int WD_CYC = 150000;

    typedef struct packed {
        logic [18:0] trim;
        logic [15:0] sum;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{{17'd5,  2'd0}, 16'd24},
        '{{17'd5,  2'd1}, 16'd25},
        '{{17'd5,  2'd2}, 16'd26},
        '{{17'd5,  2'd3}, 16'd27},
        '{{17'd1,  2'd3}, 16'd11},
        '{{17'd12, 2'd2}, 16'd54},
        '{{17'd31, 2'd1}, 16'd129}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_data = '0;
    logic        tick;

    int n_chk = 0;
    int n_bad = 0;
    int tcount = 0;
    int act_c = RSTC, act_f = 0, stg_c = RSTC, stg_f = 0;
    bit pend = 1'b0;

    always #2.5 clk = ~clk;

    rtc_rate_trim #(.RST_COARSE(RSTC)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .tick_o    (tick)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int exp_period();
        return act_c + 1 + (((tcount % 4) < act_f) ? 1 : 0);
    endfunction

    task automatic stage_model(input logic [18:0] d);
        stg_c = int'(d[18:2]);
        stg_f = int'(d[1:0]);
        pend  = 1'b1;
    endtask

    // Called at the negedge just after a tick (or after reset release); measures one second.
    task automatic sec(input bit w, input logic [18:0] d, input bit w2, input logic [18:0] d2,
                       input string req, output int p);
        int e;
        e = exp_period();
        if (w) begin
            wr_en = 1'b1;
            wr_data = d;
            stage_model(d);
        end
        p = 0;
        do begin
            @(negedge clk);
            p++;
            if (p == 1) begin
                if (w2) begin
                    wr_data = d2;
                    stage_model(d2);
                end else begin
                    wr_en = 1'b0;
                end
            end else if (p == 2) begin
                wr_en = 1'b0;
            end
        end while (!tick && p < MAXP);
        tcount++;
        if (pend) begin
            act_c = stg_c;
            act_f = stg_f;
            pend  = 1'b0;
        end
        check(p == e, req, p, e);
    endtask

    initial begin
        #(WD_CYC * 5.0);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        int sum;
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R1 tick low in reset", tick, 0);
        rst_n = 1'b1;
        sec(1'b0, '0, 1'b0, '0, "R1 first second", p);

        // Vector table walk: R2 layout, R3/R4 per-second periods, R5 four-second sum, R6 delay
        for (int i = 0; i < 7; i++) begin
            sec(1'b1, VECS[i].trim, 1'b0, '0, "R6 old period while staged", p);
            sum = 0;
            for (int k = 0; k < 4; k++) begin
                sec(1'b0, '0, 1'b0, '0, "R3 R4 second length", p);
                sum += p;
            end
            check(sum == int'(VECS[i].sum), "R5 R2 R10 four-second total", sum, int'(VECS[i].sum));
        end

        // R9 then R7: write sampled on the boundary edge waits one more second
        begin
            int e;
            e = exp_period();
            @(negedge clk);
            check(tick == 1'b0, "R9 tick one cycle", tick, 0);
            repeat (e - 2) @(negedge clk);
            wr_en = 1'b1;
            wr_data = {17'd9, 2'd1};
            @(negedge clk);
            wr_en = 1'b0;
            check(tick == 1'b1, "R7 boundary at predicted edge", tick, 1);
            tcount++;
            stage_model({17'd9, 2'd1});
            sec(1'b0, '0, 1'b0, '0, "R7 write on boundary not yet applied", p);
            sec(1'b0, '0, 1'b0, '0, "R7 applied at following boundary", p);
        end

        // R8: two writes in one second, the last one wins
        sec(1'b1, {17'd20, 2'd0}, 1'b1, {17'd7, 2'd2}, "R6 old period during writes", p);
        for (int k = 0; k < 4; k++) begin
            sec(1'b0, '0, 1'b0, '0, "R8 last write applied", p);
        end

        // R1: reset in mid-second restores the default setting
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(tick == 1'b0, "R1 tick low after mid-run reset", tick, 0);
        rst_n = 1'b1;
        tcount = 0;
        act_c = RSTC; act_f = 0; stg_c = RSTC; stg_f = 0; pend = 1'b0;
        sec(1'b0, '0, 1'b0, '0, "R1 default period after reset", p);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule